// File: doc/BRIEF.md
# Accumulator-Based Minimal CPU Core

This block is a very small stored-program processor. It holds 32 words of 32-bit storage, a signed 32-bit accumulator, a 5-bit current-instruction address and a 32-bit present-instruction register. Each executed cycle first advances the address by one, modulo 32. It then fetches the word at the new address into the present-instruction register and carries that word out in the same clock. Because the address moves before the fetch, a jump lands on the word after the one it names. The instruction set has no load and no add. It offers negated load, subtract, store, two indirect jumps, a skip on a negative accumulator and a halt.

The core starts halted. A start pulse sets it running until it meets a halt instruction or an enabled breakpoint address. A step pulse given while halted executes one instruction. While the core is halted, a side port can read and write any storage word, which is how a program is loaded and inspected. The reason for the last stop is reported as a code.

Top module: `acc_cpu_core`

## Requirements
- R1: Storage has 32 words of 32 bits, and every 5-bit address is valid. While the core is halted, `dbg_rdata_o` shows the word at `dbg_addr_i` combinationally, and `dbg_we_i` writes `dbg_wdata_i` there on the clock edge.
- R2: The function code sits in instruction bits 15..13 and the operand address n in bits 4..0. All other bits of the word have no effect on execution.
- R3: Each executed instruction first sets the current address to (address + 1) mod 32. It then loads the word at that address into `pi_o` and executes it, so address 31 is followed by address 0.
- R4: Code 0 sets the current address to bits 4..0 of S[n]. Code 1 adds S[n] to the already advanced address, keeping the low 5 bits of the sum.
- R5: Code 2 sets the accumulator to the two's-complement negation of S[n], modulo 2^32.
- R6: Code 3 writes the accumulator into S[n]. The accumulator does not change.
- R7: Code 4 subtracts S[n] from the accumulator modulo 2^32. Code 5 behaves exactly like code 4.
- R8: Code 6 adds one more to the advanced address when accumulator bit 31 is set, and otherwise does nothing. It ignores n.
- R9: Code 7 halts the core with `stop_code_o` = 1. The advance of the address and the fetch still take place.
- R10: While running, if breakpoints are enabled and the current address equals `bp_addr_i` before the advance, the core halts with `stop_code_o` = 2. The address, the accumulator and storage are left unchanged. The first cycle after a start is exempt from this check.
- R11: A step pulse while halted, with no start in the same cycle, executes exactly one instruction and leaves the core halted. The stop code becomes 1 if that instruction was a halt and 0 otherwise. A start pulse clears the stop code to 0.
- R12: While running, `dbg_we_i` has no effect on storage and `dbg_rdata_o` reads 0.
- R13: Synchronous active-low reset clears the accumulator, the current address, the present instruction and the stop code, and leaves the core halted. Storage keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that leaves the halted state and runs |
| step_i | input | 1 | Pulse that executes one instruction while halted |
| bp_en_i | input | 1 | Enables the breakpoint address compare |
| bp_addr_i | input | 5 | Breakpoint address |
| dbg_we_i | input | 1 | Side-port write strobe (halted only) |
| dbg_addr_i | input | 5 | Side-port storage address |
| dbg_wdata_i | input | 32 | Side-port write data |
| dbg_rdata_o | output | 32 | Side-port read data, 0 while running |
| halted_o | output | 1 | Core is halted |
| stop_code_o | output | 2 | 0 none, 1 halt instruction, 2 breakpoint |
| acc_o | output | 32 | Accumulator |
| ci_o | output | 5 | Current-instruction address |
| pi_o | output | 32 | Present-instruction register |

## Verification
Every function code is run as a single stepped instruction after a preset negated load. The operands and accumulator values are picked to separate the wrapping cases from the plain ones: a jump word with high bits set, a negative relative offset, negating the most negative value, subtracting across the sign boundary, and the skip on negative, zero and largest positive accumulators. Some vectors put ones in every ignored instruction bit to show that only the two fields are decoded. Directed runs cover a full program ending in a halt, a breakpoint stop followed by a resume, the wrap of the address from 31 to 0, and side-port writes tried while running. A reset check confirms that storage survives while the registers clear.

// File: rtl/acc_cpu_pkg.sv
// Shared definitions for the accumulator CPU core: instruction field
// positions, the function-code enumeration and the stop-reason codes.
package acc_cpu_pkg;

    // Position and width of the function field inside an instruction word.
    localparam int OP_LSB = 13;
    localparam int OP_W   = 3;

    // Function codes; the numeric values are the encoded instruction field.
    typedef enum logic [OP_W-1:0] {
        OP_JMP  = 3'd0,   // absolute indirect jump
        OP_JRL  = 3'd1,   // relative indirect jump
        OP_LDN  = 3'd2,   // load negated
        OP_STO  = 3'd3,   // store accumulator
        OP_SUB  = 3'd4,   // subtract
        OP_SUBX = 3'd5,   // alias of subtract
        OP_SKN  = 3'd6,   // skip next word if accumulator negative
        OP_HLT  = 3'd7    // halt
    } op_e;

    // Reason for the most recent stop.
    typedef enum logic [1:0] {
        STOP_NONE = 2'd0,
        STOP_HALT = 2'd1,
        STOP_BRK  = 2'd2
    } stop_e;

endpackage

// File: rtl/acc_cpu_store.sv
// Word storage for the core.
// Does: holds 2**ADDR_W words with NRD independent combinational read
//       ports and one synchronous write port.
// Assumes: the caller arbitrates the single write port; contents are not
//          touched by reset so a loaded program survives it.
module acc_cpu_store #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    parameter int NRD    = 3
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i [NRD],
    output logic [WORD_W-1:0] rdata_o [NRD]
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    // Write one word on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    // One asynchronous read path per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = cells[raddr_i[p]];
    end

endmodule

// File: rtl/acc_cpu_exec.sv
// Execute stage of the core.
// Does: from the decoded function, the operand word, the accumulator and
//       the already advanced address, works out the next address, the
//       next accumulator value and the store and halt requests.
// Assumes: the results are applied only in a cycle where the sequencer
//          allows execution; arithmetic wraps with no overflow flag.
module acc_cpu_exec
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  op_e               op_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] ci_inc_i,
    output logic [ADDR_W-1:0] ci_next_o,
    output logic [WORD_W-1:0] acc_next_o,
    output logic              acc_we_o,
    output logic              store_o,
    output logic              halt_o
);

    logic [ADDR_W-1:0] opnd_lo;
    logic [ADDR_W-1:0] skip_amt;

    assign opnd_lo  = operand_i[ADDR_W-1:0];
    assign skip_amt = ADDR_W'(acc_i[WORD_W-1]);

    // Decode the function code into next-state values.
    always_comb begin
        ci_next_o  = ci_inc_i;
        acc_next_o = acc_i;
        acc_we_o   = 1'b0;
        store_o    = 1'b0;
        halt_o     = 1'b0;
        unique case (op_i)
            OP_JMP: ci_next_o = opnd_lo;
            OP_JRL: ci_next_o = ci_inc_i + opnd_lo;
            OP_LDN: begin
                acc_next_o = '0 - operand_i;
                acc_we_o   = 1'b1;
            end
            OP_STO: store_o = 1'b1;
            OP_SUB, OP_SUBX: begin
                acc_next_o = acc_i - operand_i;
                acc_we_o   = 1'b1;
            end
            OP_SKN: ci_next_o = ci_inc_i + skip_amt;
            OP_HLT: halt_o = 1'b1;
            default: ci_next_o = ci_inc_i;
        endcase
    end

endmodule

// File: rtl/acc_cpu_seq.sv
// Run/halt sequencer of the core.
// Does: keeps the running flag, a first-cycle-after-start flag and the
//       stop code; decides in which cycles an instruction executes.
// Assumes: start_i and step_i are pulses; start wins over step; the
//          breakpoint compare uses the address before it is advanced.
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic              bp_en_i,
    input  logic [ADDR_W-1:0] bp_addr_i,
    input  logic [ADDR_W-1:0] ci_i,
    input  logic              halt_req_i,
    output logic              exec_o,
    output logic              halted_o,
    output stop_e             stop_code_o
);

    logic  running_q;
    logic  first_q;
    stop_e code_q;
    logic  bp_hit;
    logic  step_go;

    assign bp_hit   = running_q && !first_q && bp_en_i && (ci_i == bp_addr_i);
    assign step_go  = !running_q && step_i && !start_i;
    assign exec_o   = (running_q && !bp_hit) || step_go;
    assign halted_o = !running_q;
    assign stop_code_o = code_q;

    // Advance the run state and record why the core stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            first_q   <= 1'b0;
            code_q    <= STOP_NONE;
        end else if (running_q) begin
            first_q <= 1'b0;
            if (bp_hit) begin
                running_q <= 1'b0;
                code_q    <= STOP_BRK;
            end else if (halt_req_i) begin
                running_q <= 1'b0;
                code_q    <= STOP_HALT;
            end
        end else if (start_i) begin
            running_q <= 1'b1;
            first_q   <= 1'b1;
            code_q    <= STOP_NONE;
        end else if (step_i) begin
            code_q <= halt_req_i ? STOP_HALT : STOP_NONE;
        end
    end

    // R10: a breakpoint match stops the core with code 2.
    a_r10_brk_stop: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |=> (halted_o && stop_code_o == STOP_BRK));

    // R9: an executed halt instruction stops the core with code 1.
    a_r9_halt_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && halt_req_i) |=> (halted_o && stop_code_o == STOP_HALT));

    // R11: a step taken while halted leaves the core halted.
    a_r11_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && step_i && !start_i) |=> halted_o);

endmodule

// File: rtl/acc_cpu_core.sv
// Accumulator CPU core top.
// Does: holds the accumulator, current-address and present-instruction
//       registers; advances, fetches and executes one instruction per
//       allowed cycle; gives a halted-only side port into storage.
// Assumes: the side port is used only while halted; a store executed by
//          a step takes the write port ahead of a side-port write.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic              bp_en_i,
    input  logic [ADDR_W-1:0] bp_addr_i,
    input  logic              dbg_we_i,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    input  logic [WORD_W-1:0] dbg_wdata_i,
    output logic [WORD_W-1:0] dbg_rdata_o,
    output logic              halted_o,
    output logic [1:0]        stop_code_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [ADDR_W-1:0] ci_o,
    output logic [WORD_W-1:0] pi_o
);

    localparam int NRD    = 3;
    localparam int RP_FET = 0;
    localparam int RP_OPD = 1;
    localparam int RP_DBG = 2;

    logic [ADDR_W-1:0] ci_q;
    logic [WORD_W-1:0] pi_q;
    logic [WORD_W-1:0] acc_q;

    logic [ADDR_W-1:0] ci_inc;
    logic [WORD_W-1:0] fetch_word;
    logic [WORD_W-1:0] operand;
    op_e               op;
    logic [ADDR_W-1:0] opnd_addr;

    logic [ADDR_W-1:0] rd_addr [NRD];
    logic [WORD_W-1:0] rd_data [NRD];

    logic [ADDR_W-1:0] ci_next;
    logic [WORD_W-1:0] acc_next;
    logic              acc_we;
    logic              store_req;
    logic              halt_req;
    logic              exec;
    logic              halted;
    stop_e             stop_code;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    // Address of the word to fetch: one past the current address.
    assign ci_inc     = ci_q + ADDR_W'(1);
    assign fetch_word = rd_data[RP_FET];
    assign op         = op_e'(fetch_word[OP_LSB +: OP_W]);
    assign opnd_addr  = fetch_word[ADDR_W-1:0];
    assign operand    = rd_data[RP_OPD];

    assign rd_addr[RP_FET] = ci_inc;
    assign rd_addr[RP_OPD] = opnd_addr;
    assign rd_addr[RP_DBG] = dbg_addr_i;

    // Single write port: an executed store first, else a halted deposit.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = dbg_addr_i;
        mem_wdata = dbg_wdata_i;
        if (exec && store_req) begin
            mem_we    = 1'b1;
            mem_waddr = opnd_addr;
            mem_wdata = acc_q;
        end else if (halted && dbg_we_i) begin
            mem_we    = 1'b1;
        end
    end

    acc_cpu_store #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .NRD    (NRD)
    ) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    acc_cpu_exec #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_exec (
        .op_i       (op),
        .operand_i  (operand),
        .acc_i      (acc_q),
        .ci_inc_i   (ci_inc),
        .ci_next_o  (ci_next),
        .acc_next_o (acc_next),
        .acc_we_o   (acc_we),
        .store_o    (store_req),
        .halt_o     (halt_req)
    );

    acc_cpu_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .bp_en_i     (bp_en_i),
        .bp_addr_i   (bp_addr_i),
        .ci_i        (ci_q),
        .halt_req_i  (halt_req),
        .exec_o      (exec),
        .halted_o    (halted),
        .stop_code_o (stop_code)
    );

    // Architectural register update for each executed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ci_q  <= '0;
            pi_q  <= '0;
            acc_q <= '0;
        end else if (exec) begin
            ci_q <= ci_next;
            pi_q <= fetch_word;
            if (acc_we) begin
                acc_q <= acc_next;
            end
        end
    end

    assign dbg_rdata_o = halted ? rd_data[RP_DBG] : '0;
    assign halted_o    = halted;
    assign stop_code_o = stop_code;
    assign acc_o       = acc_q;
    assign ci_o        = ci_q;
    assign pi_o        = pi_q;

    // R13: reset leaves the registers cleared and the core halted.
    a_r13_reset_state: assert property (@(posedge clk)
        !rst_n |=> (halted_o && acc_o == '0 && ci_o == '0 && pi_o == '0
                    && stop_code_o == 2'd0));

    // R3: the present-instruction register takes the fetched word.
    a_r3_fetch_pi: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (pi_o == $past(fetch_word)));

    // R5: a negated load gives zero minus the operand.
    a_r5_ldn: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LDN) |=> (acc_o == WORD_W'('0 - $past(operand))));

    // R7: both subtract codes take the operand off the accumulator.
    a_r7_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == OP_SUB || op == OP_SUBX))
        |=> (acc_o == WORD_W'($past(acc_o) - $past(operand))));

    // R8: with a non-negative accumulator the skip only advances by one.
    a_r8_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_SKN && !acc_o[WORD_W-1])
        |=> (ci_o == ADDR_W'($past(ci_o) + ADDR_W'(1))));

    // R6: a store leaves the accumulator as it was.
    a_r6_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_STO) |=> $stable(acc_o));

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

    localparam logic [31:0] IGN = 32'hFFFF_1FE0;  // every ignored bit

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] opval;
        logic [31:0] acc0;
        logic [31:0] exp_acc;
        logic [4:0]  exp_ci;
        logic [31:0] exp_mem;
    } vec_t;

    // Word 1 = negated load of word 20 (holds -acc0), word 2 = instr under
    // test with operand address 24 (holds opval); two steps are taken.
    localparam vec_t VECS [13] = '{
        '{32'h0000_0018, 32'h0000_0009, 32'h5,         32'h5,         5'd9, 32'h0000_0009}, // R4 jump
        '{32'hFFFF_1FF8, 32'hFFFF_FFE7, 32'h5,         32'h5,         5'd7, 32'hFFFF_FFE7}, // R4 R2 truncate
        '{32'h0000_2018, 32'h0000_0005, 32'h1,         32'h1,         5'd7, 32'h0000_0005}, // R4 relative
        '{32'h0000_2018, 32'hFFFF_FFFF, 32'h1,         32'h1,         5'd1, 32'hFFFF_FFFF}, // R4 relative back
        '{32'h0000_4018, 32'h0000_0007, 32'h3,         32'hFFFF_FFF9, 5'd2, 32'h0000_0007}, // R5
        '{32'hFFFF_5FF8, 32'h8000_0000, 32'h0,         32'h8000_0000, 5'd2, 32'h8000_0000}, // R5 R2 min
        '{32'h0000_6018, 32'hAAAA_5555, 32'h1234_5678, 32'h1234_5678, 5'd2, 32'h1234_5678}, // R6
        '{32'h0000_8018, 32'h0000_0003, 32'hA,         32'h7,         5'd2, 32'h0000_0003}, // R7
        '{32'h0000_8018, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 5'd2, 32'h0000_0001}, // R7 wrap
        '{32'h0000_A018, 32'h0000_0003, 32'hA,         32'h7,         5'd2, 32'h0000_0003}, // R7 code 5
        '{32'h0000_C018, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 32'h0000_0000}, // R8 skip
        '{32'h0000_C018, 32'h0000_0000, 32'h0,         32'h0,         5'd2, 32'h0000_0000}, // R8 zero
        '{32'hFFFF_DFF8, 32'h0000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd2, 32'h0000_0000}  // R8 R2 positive
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        step_i = 1'b0;
    logic        bp_en_i = 1'b0;
    logic [4:0]  bp_addr_i = '0;
    logic        dbg_we_i = 1'b0;
    logic [4:0]  dbg_addr_i = '0;
    logic [31:0] dbg_wdata_i = '0;
    logic [31:0] dbg_rdata_o;
    logic        halted_o;
    logic [1:0]  stop_code_o;
    logic [31:0] acc_o;
    logic [4:0]  ci_o;
    logic [31:0] pi_o;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_cpu_core u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .bp_en_i     (bp_en_i),
        .bp_addr_i   (bp_addr_i),
        .dbg_we_i    (dbg_we_i),
        .dbg_addr_i  (dbg_addr_i),
        .dbg_wdata_i (dbg_wdata_i),
        .dbg_rdata_o (dbg_rdata_o),
        .halted_o    (halted_o),
        .stop_code_o (stop_code_o),
        .acc_o       (acc_o),
        .ci_o        (ci_o),
        .pi_o        (pi_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [31:0] instr);
        case (instr[15:13])
            3'd0, 3'd1: return "R4";
            3'd2:       return "R5";
            3'd3:       return "R6";
            3'd4, 3'd5: return "R7";
            3'd6:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic poke(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); dbg_we_i = 1'b1; dbg_addr_i = a; dbg_wdata_i = d;
        @(negedge clk); dbg_we_i = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        dbg_addr_i = a;
        #1 d = dbg_rdata_o;
    endtask

    task automatic step_once();
        @(negedge clk); step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
    endtask

    task automatic run_until_halt(input string tag);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < 200 && !halted_o; k++) @(negedge clk);
        check({tag, " halted after run"}, 32'(halted_o), 32'd1);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nchecks++; nerr++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R13: state right after reset
        check("R13 halted", 32'(halted_o), 32'd1);
        check("R13 stop code", 32'(stop_code_o), 32'd0);
        check("R13 acc", acc_o, 32'd0);
        check("R13 ci", 32'(ci_o), 32'd0);
        check("R13 pi", pi_o, 32'd0);

        // Vector walk: one stepped instruction per entry
        for (int i = 0; i < 13; i++) begin
            string t;
            t = tag_of(VECS[i].instr);
            if ((VECS[i].instr & IGN) != 0) t = {"R2 ", t};
            do_reset();
            poke(5'd1, 32'h0000_4014);
            poke(5'd2, VECS[i].instr);
            poke(5'd20, 32'd0 - VECS[i].acc0);
            poke(5'd24, VECS[i].opval);
            step_once();
            check($sformatf("R11 vec%0d one step ci", i), 32'(ci_o), 32'd1);
            step_once();
            check($sformatf("%s vec%0d acc", t, i), acc_o, VECS[i].exp_acc);
            check($sformatf("%s vec%0d ci", t, i), 32'(ci_o), 32'(VECS[i].exp_ci));
            check($sformatf("R3 vec%0d pi", i), pi_o, VECS[i].instr);
            check($sformatf("R11 vec%0d still halted", i), 32'(halted_o), 32'd1);
            peek(5'd24, rd);
            check($sformatf("%s vec%0d S[24]", (VECS[i].instr[15:13] == 3'd3) ? "R6" : "R1", i),
                  rd, VECS[i].exp_mem);
        end

        // R13: reset keeps storage
        do_reset();
        peek(5'd20, rd);
        check("R13 storage kept", rd, 32'h8000_0001);
        check("R13 acc cleared", acc_o, 32'd0);

        // R9: program run ending on halt
        poke(5'd1, 32'h0000_4014);   // acc = 10
        poke(5'd2, 32'h0000_8015);   // acc -= 4
        poke(5'd3, 32'h0000_E000);   // halt
        poke(5'd20, 32'hFFFF_FFF6);
        poke(5'd21, 32'h0000_0004);
        run_until_halt("R9");
        check("R9 stop code", 32'(stop_code_o), 32'd1);
        check("R9 ci", 32'(ci_o), 32'd3);
        check("R9 pi", pi_o, 32'h0000_E000);
        check("R9 acc", acc_o, 32'd6);

        // R10: breakpoint on address 2, then resume
        do_reset();
        bp_en_i = 1'b1; bp_addr_i = 5'd2;
        run_until_halt("R10");
        check("R10 stop code", 32'(stop_code_o), 32'd2);
        check("R10 ci", 32'(ci_o), 32'd2);
        check("R10 acc", acc_o, 32'd6);
        run_until_halt("R10 resume");
        check("R10 resume stop code", 32'(stop_code_o), 32'd1);
        check("R10 resume ci", 32'(ci_o), 32'd3);
        bp_en_i = 1'b0;

        // R3: address wraps from 31 to 0
        do_reset();
        poke(5'd0, 32'h0000_E000);
        poke(5'd31, 32'h0000_E000);
        poke(5'd1, 32'h0000_0019);   // jump via word 25
        poke(5'd25, 32'd30);
        run_until_halt("R3");
        check("R3 ci at 31", 32'(ci_o), 32'd31);
        run_until_halt("R3 wrap");
        check("R3 ci wrapped", 32'(ci_o), 32'd0);
        check("R3 pi wrapped", pi_o, 32'h0000_E000);

        // R12: side-port writes ignored while running
        do_reset();
        poke(5'd25, 32'd0);          // endless loop on word 1
        poke(5'd30, 32'h0000_5A5A);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 running", 32'(halted_o), 32'd0);
        peek(5'd30, rd);
        check("R12 read while running", rd, 32'd0);
        poke(5'd30, 32'h0000_1111);
        do_reset();
        peek(5'd30, rd);
        check("R12 word unchanged", rd, 32'h0000_5A5A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule